// File: doc/BRIEF.md
# Carry-Save Multioperand Accumulator

This block adds a bank of M unsigned L-bit operands and returns their N-bit total. It keeps the running total in redundant form, as a partial-sum vector and a carry vector. On every clock it takes one operand and reduces it together with both vectors through a row of independent full adders. No carry travels between bit positions during accumulation. The two vectors are merged by a single ordinary two-input adder only after the last operand.

To start a run, the user pulses `start` for one cycle while presenting the whole packed operand bank. The bank must be held steady until `done` is seen. The register width is N = L + ceil(log2 M), so no total of M operands can overflow.

Top module: `csa_multiop_acc`

## Requirements
- R1: An accepted start clears both the partial-sum and the carry register to zero, so a new run never inherits the previous total.
- R2: After an accepted start, operand index 0 through M-1 is absorbed, one per clock, in increasing index order. Operand k sits in bits [k*L+L-1 : k*L] of `opnds`.
- R3: Each absorbing clock forms the new partial-sum bit i as the XOR of the selected operand, partial-sum and carry bits at position i. The majority of those three bits goes to position i+1 of the new carry vector, and carry bit 0 is always zero.
- R4: After operand k has been absorbed, partial-sum plus carry equals the total of operands 0..k.
- R5: `result` equals the exact sum of all M operands, including when every operand is all ones, with N = L + ceil(log2 M). For M = 1, N = L and the result equals the single operand.
- R6: `done` is high for exactly one cycle, M+1 clock edges after the edge that accepted start, and `result` is valid in that cycle.
- R7: A start pulse that arrives while a run is in progress is ignored. The run neither restarts nor changes its completion time.
- R8: `result` changes only in a cycle where `done` is high, and otherwise holds its value until the next run completes.
- R9: After reset, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| opnds | input | M*L | Packed operand bank, operand k in slice k |
| done | output | 1 | One-cycle flag marking a fresh result |
| result | output | N | Sum of all operands |

## Verification
The hardest condition to reach from the ports is a second start that lands in the middle of a run. In that case, a restart would look like a correct result that simply arrives late. The stimulus pulses start again a few clocks into a run and then demands `done` on exactly the original cycle. A back-to-back run after a large total shows whether the redundant registers were truly cleared. The running invariant between the two vectors is watched inside the block on every absorbing cycle.

// File: rtl/csa_multiop_acc.sv
module csa_multiop_acc #(
  parameter int L = 8,
  parameter int M = 6,
  localparam int N = L + $clog2(M),
  localparam int IW = (M > 1) ? $clog2(M) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [M*L-1:0] opnds,
  output logic           done,
  output logic [N-1:0]   result
);

  logic          busy, fin;
  logic [IW-1:0] idx;
  logic [N-1:0]  ps, cy;
  logic [L-1:0]  sel;
  logic [N-1:0]  ext, ps_nx, maj, cy_nx;
  logic          last, take;

  assign sel   = opnds[idx*L +: L];
  assign ext   = N'(sel);
  assign ps_nx = ext ^ ps ^ cy;
  assign maj   = (ext & ps) | (ext & cy) | (ps & cy);
  assign cy_nx = {maj[N-2:0], 1'b0};
  assign last  = (idx == IW'(M-1));
  assign take  = start && !busy && !fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      idx    <= '0;
      ps     <= '0;
      cy     <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy <= 1'b1;
        idx  <= '0;
        ps   <= '0;
        cy   <= '0;
      end else if (busy) begin
        ps  <= ps_nx;
        cy  <= cy_nx;
        idx <= idx + IW'(1);
        if (last) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (fin) begin
        fin    <= 1'b0;
        result <= ps + cy;
        done   <= 1'b1;
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ps == '0 && cy == '0 && idx == '0 && busy)); // R1

  AST_INDEX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && idx == $past(idx) + IW'(1))); // R2

  AST_CARRY_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !cy[0]); // R3

  AST_TOTAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (N'(ps + cy) == N'($past(ps) + $past(cy) + $past(ext)))); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> ##1 done); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && idx != '0) |=> (idx != '0 || fin)); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R8

endmodule

// File: tb/test_csa_multiop_acc.sv
module test_csa_multiop_acc;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;
  localparam int M = 6;
  localparam int N = L + $clog2(M);
  localparam int NV = 6;
  localparam logic [M*L-1:0] VEC [NV] = '{
    48'h0000_0000_0000,
    48'hFFFF_FFFF_FFFF,
    48'h0102_0408_1020,
    48'h5A3C_E117_08F0,
    48'h8080_8080_8080,
    48'hC3D2_7E01_FF6B
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M*L-1:0] opnds = '0;
  logic done;
  logic [N-1:0] result;
  logic start1 = 1'b0;
  logic [L-1:0] op1 = '0;
  logic done1;
  logic [L-1:0] result1;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_multiop_acc #(.L(L), .M(M)) i_csa_multiop_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .opnds(opnds),
    .done(done), .result(result));

  csa_multiop_acc #(.L(L), .M(1)) i_csa_multiop_acc_m1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .opnds(op1),
    .done(done1), .result(result1));

  function automatic int ref_sum(logic [M*L-1:0] b);
    int s = 0;
    for (int k = 0; k < M; k++) s += int'(b[k*L +: L]);
    return s;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(logic [M*L-1:0] b, bit restart_mid);
    @(negedge clk);
    opnds = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= M; c++) begin
      if (restart_mid && c == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, restart_mid ? "R7 early done" : "R6 early done", int'(done), 0);
    end
    @(negedge clk);
    check(done == 1'b1, restart_mid ? "R7 done on time" : "R6 done on time", int'(done), 1);
    check(int'(result) == ref_sum(b), "R5 R2 R3 R4 sum", int'(result), ref_sum(b));
    @(negedge clk);
    check(done == 1'b0, "R6 single cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    #(CLK_PERIOD * 2 + 1);
    check(done == 1'b0, "R9 done", int'(done), 0);
    check(result == '0, "R9 result", int'(result), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);

    // R1: large total followed at once by a small one
    run(48'hFFFF_FFFF_FFFF, 1'b0);
    run(48'h0000_0000_0001, 1'b0);

    // R7: second start mid-run must not restart
    run(48'h1122_3344_5566, 1'b1);

    // R8: result holds while inputs change and no run is active
    held = result;
    @(negedge clk);
    opnds = 48'hDEAD_BEEF_CAFE;
    repeat (5) @(negedge clk);
    check(result == held, "R8 hold", int'(result), int'(held));
    check(done == 1'b0, "R8 no done", int'(done), 0);

    // R5 M=1 instance: result equals the single operand, done after 2 edges
    @(negedge clk);
    op1 = 8'hFF;
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    @(negedge clk);
    check(done1 == 1'b0, "R6 m1 early", int'(done1), 0);
    @(negedge clk);
    check(done1 == 1'b1, "R6 m1 done", int'(done1), 1);
    check(result1 == 8'hFF, "R5 m1 sum", int'(result1), 255);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule